// File: doc/BRIEF.md
# Locality Access Arbiter

This block sits between a bus engine that has already decoded a register access and the register file of a security module that exposes five localities. For every request it decides whether the access is carried out or aborted. It then reports the side effect the register file must apply, such as a plain read or write, an interrupt clear, a FIFO pop or push, or a hash start, data or end action. The decision depends on which locality the address names and on whether that locality owns the block, another locality owns it, or no locality does.

The arbiter keeps the ownership state itself. It also keeps a data-available flag, which the command side sets and clears. Ownership changes in three ways: through request and release bits in the access register, through a hash start, which hands ownership to the highest locality, and through a hash end, which gives it up. Every decision appears exactly one clock after the request, together with the ownership state that results from it.

Top module: `lra_top`

## Requirements
- R1: While rst_ni is low and after it rises with no request, resp_valid_o is 0, active_valid_o is 0 and avail_o is 0.
- R2: A request sampled at a clock edge yields resp_valid_o=1 for one cycle after that edge. An abort gives resp_ok_o=0 and resp_act_o=0. Accepted action codes are: 1 read, 2 write, 3 interrupt clear, 4 FIFO pop, 5 FIFO push, 6 hash start, 7 hash data, 8 hash end, 9 access write.
- R3: The locality is taken from address bits [15:12], and values above 4 abort. Register offsets in bits [11:0] are: access 0x000, int-enable 0x008, int-vector 0x00C, int-status 0x010, int-capability 0x014, status 0x018, hash end 0x020, FIFO 0x024, hash start 0x028, hash data 0x02C, config 0xF00. Any other offset aborts.
- R4: The status register is read (1) or written (2) only by the owning locality. Every other status access aborts.
- R5: Int-enable, int-vector and config are readable by any locality. A write is accepted (2) only from the owner.
- R6: Int-status is readable by any locality, and a write from the owner gives code 3. A write from a non-owner aborts. Int-capability is readable by any locality, and every write to it aborts.
- R7: The access register is accepted from any locality (read 1, write 9). A write with bit 5 set by the owner releases ownership. Otherwise, a write with bit 1 set while no locality owns grants ownership to the writer. Any other access write leaves ownership unchanged.
- R8: A FIFO read is accepted (4) only from the owner while avail_o is 1. A FIFO write is accepted (5) only from the owner.
- R9: A hash-start write from the owner, or while no locality owns, is accepted (6) and makes locality 4 the owner. Otherwise it aborts. Reads of hash start, hash data and hash end abort.
- R10: Hash data (7) and hash end (8) writes are accepted only from the owner. An accepted hash end releases ownership.
- R11: avail_set_i sets avail_o at the next edge and avail_clr_i clears it. When both are high, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded access present this cycle |
| req_addr_i | input | 16 | Locality in [15:12], register offset in [11:0] |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 8 | Write data (access register control bits) |
| avail_set_i | input | 1 | Response data became available |
| avail_clr_i | input | 1 | Response data drained |
| resp_valid_o | output | 1 | Decision valid |
| resp_ok_o | output | 1 | 1 accept, 0 abort |
| resp_act_o | output | 4 | Side-effect code |
| active_valid_o | output | 1 | Some locality owns the block |
| active_loc_o | output | 3 | Owning locality |
| avail_o | output | 1 | Data-available flag |

## Verification
The bench builds the block with its default parameters: five localities, a four-bit locality field and a twelve-bit offset. This lets it reach every owner/other/none combination, the hash locality 4, and the locality values 5 to 15, which have to abort. A directed sequence walks each register through all three ownership conditions and the transfers of ownership. A long run of pseudo-random requests then mixes in invalid offsets and localities, while a behavioural model checks the outputs every cycle.

// File: rtl/lra_pkg.sv
package lra_pkg;
  typedef enum logic [3:0] {
    ACT_NONE       = 4'd0,
    ACT_READ       = 4'd1,
    ACT_WRITE      = 4'd2,
    ACT_INT_CLR    = 4'd3,
    ACT_FIFO_RD    = 4'd4,
    ACT_FIFO_WR    = 4'd5,
    ACT_HASH_START = 4'd6,
    ACT_HASH_DATA  = 4'd7,
    ACT_HASH_END   = 4'd8,
    ACT_ACC_WR     = 4'd9
  } act_e;

  typedef enum logic [3:0] {
    RID_ACCESS, RID_INT_EN, RID_INT_VEC, RID_INT_STS, RID_INT_CAP, RID_STS,
    RID_FIFO, RID_HASH_START, RID_HASH_DATA, RID_HASH_END, RID_CFG, RID_NONE
  } rid_e;

  localparam logic [11:0] OFF_ACCESS     = 12'h000;
  localparam logic [11:0] OFF_INT_EN     = 12'h008;
  localparam logic [11:0] OFF_INT_VEC    = 12'h00C;
  localparam logic [11:0] OFF_INT_STS    = 12'h010;
  localparam logic [11:0] OFF_INT_CAP    = 12'h014;
  localparam logic [11:0] OFF_STS        = 12'h018;
  localparam logic [11:0] OFF_HASH_END   = 12'h020;
  localparam logic [11:0] OFF_FIFO       = 12'h024;
  localparam logic [11:0] OFF_HASH_START = 12'h028;
  localparam logic [11:0] OFF_HASH_DATA  = 12'h02C;
  localparam logic [11:0] OFF_CFG        = 12'hF00;

  localparam int REQ_BIT = 1;
  localparam int REL_BIT = 5;
endpackage

// File: rtl/lra_decode.sv
module lra_decode
  import lra_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_LSB   = 12,
  parameter int NUM_LOC   = 5,
  parameter int LOC_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 loc_ok_o,
  output logic [LOC_IDX_W-1:0] loc_idx_o,
  output rid_e                 rid_o
);
  localparam int LF_W = ADDR_W - LOC_LSB;

  logic [LF_W-1:0]    loc_field;
  logic [LOC_LSB-1:0] off;

  assign loc_field = addr_i[ADDR_W-1:LOC_LSB];
  assign off       = addr_i[LOC_LSB-1:0];
  assign loc_ok_o  = loc_field < LF_W'(NUM_LOC);
  assign loc_idx_o = loc_field[LOC_IDX_W-1:0];

  always_comb begin
    unique case (off)
      LOC_LSB'(OFF_ACCESS):     rid_o = RID_ACCESS;
      LOC_LSB'(OFF_INT_EN):     rid_o = RID_INT_EN;
      LOC_LSB'(OFF_INT_VEC):    rid_o = RID_INT_VEC;
      LOC_LSB'(OFF_INT_STS):    rid_o = RID_INT_STS;
      LOC_LSB'(OFF_INT_CAP):    rid_o = RID_INT_CAP;
      LOC_LSB'(OFF_STS):        rid_o = RID_STS;
      LOC_LSB'(OFF_HASH_END):   rid_o = RID_HASH_END;
      LOC_LSB'(OFF_FIFO):       rid_o = RID_FIFO;
      LOC_LSB'(OFF_HASH_START): rid_o = RID_HASH_START;
      LOC_LSB'(OFF_HASH_DATA):  rid_o = RID_HASH_DATA;
      LOC_LSB'(OFF_CFG):        rid_o = RID_CFG;
      default:                  rid_o = RID_NONE;
    endcase
  end
endmodule

// File: rtl/lra_rights.sv
module lra_rights
  import lra_pkg::*;
#(
  parameter int LOC_IDX_W = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 loc_ok_i,
  input  logic [LOC_IDX_W-1:0] loc_idx_i,
  input  rid_e                 rid_i,
  input  logic                 write_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 act_vld_i,
  input  logic [LOC_IDX_W-1:0] act_loc_i,
  input  logic                 avail_i,
  output logic                 ok_o,
  output act_e                 act_o,
  output logic                 grant_o,
  output logic                 release_o,
  output logic                 hstart_o
);
  logic own, free;
  assign own  = act_vld_i && (act_loc_i == loc_idx_i);
  assign free = !act_vld_i;

  always_comb begin
    act_o     = ACT_NONE;
    grant_o   = 1'b0;
    release_o = 1'b0;
    hstart_o  = 1'b0;
    if (loc_ok_i) begin
      unique case (rid_i)
        RID_ACCESS: begin
          act_o = write_i ? ACT_ACC_WR : ACT_READ;
          if (write_i) begin
            if (wdata_i[REL_BIT] && own)      release_o = 1'b1;
            else if (wdata_i[REQ_BIT] && free) grant_o  = 1'b1;
          end
        end
        RID_INT_EN, RID_INT_VEC, RID_CFG:
          if (!write_i)  act_o = ACT_READ;
          else if (own)  act_o = ACT_WRITE;
        RID_INT_STS:
          if (!write_i)  act_o = ACT_READ;
          else if (own)  act_o = ACT_INT_CLR;
        RID_INT_CAP:
          if (!write_i)  act_o = ACT_READ;
        RID_STS:
          if (own)       act_o = write_i ? ACT_WRITE : ACT_READ;
        RID_FIFO:
          if (write_i && own)              act_o = ACT_FIFO_WR;
          else if (!write_i && own && avail_i) act_o = ACT_FIFO_RD;
        RID_HASH_START:
          if (write_i && (own || free)) begin
            act_o    = ACT_HASH_START;
            hstart_o = 1'b1;
          end
        RID_HASH_DATA:
          if (write_i && own) act_o = ACT_HASH_DATA;
        RID_HASH_END:
          if (write_i && own) begin
            act_o     = ACT_HASH_END;
            release_o = 1'b1;
          end
        default: act_o = ACT_NONE;
      endcase
    end
    ok_o = (act_o != ACT_NONE);
  end
endmodule

// File: rtl/lra_owner.sv
module lra_owner #(
  parameter int NUM_LOC   = 5,
  parameter int LOC_IDX_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [LOC_IDX_W-1:0] loc_idx_i,
  input  logic                 grant_i,
  input  logic                 release_i,
  input  logic                 hstart_i,
  input  logic                 avail_set_i,
  input  logic                 avail_clr_i,
  output logic                 act_vld_o,
  output logic [LOC_IDX_W-1:0] act_loc_o,
  output logic                 avail_o
);
  localparam logic [LOC_IDX_W-1:0] HASH_LOC = LOC_IDX_W'(NUM_LOC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_vld_o <= 1'b0;
      act_loc_o <= '0;
    end else if (fire_i) begin
      if (hstart_i) begin
        act_vld_o <= 1'b1;
        act_loc_o <= HASH_LOC;
      end else if (release_i) begin
        act_vld_o <= 1'b0;
      end else if (grant_i) begin
        act_vld_o <= 1'b1;
        act_loc_o <= loc_idx_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          avail_o <= 1'b0;
    else if (avail_set_i) avail_o <= 1'b1;
    else if (avail_clr_i) avail_o <= 1'b0;
  end

  AST_HASH_SEIZES_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && hstart_i |=> act_vld_o && act_loc_o == HASH_LOC); // R9
  AST_RELEASE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && release_i && !hstart_i |=> !act_vld_o); // R7
  AST_OWNER_SWAP_BY_HASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_o && $past(act_vld_o) && act_loc_o != $past(act_loc_o) |-> $past(fire_i && hstart_i)); // R9
  AST_AVAIL_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_set_i |=> avail_o); // R11
endmodule

// File: rtl/lra_top.sv
module lra_top
  import lra_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOC_LSB = 12,
  parameter int NUM_LOC = 5,
  parameter int DATA_W  = 8,
  parameter int LOC_IDX_W = $clog2(NUM_LOC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_write_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic                 avail_set_i,
  input  logic                 avail_clr_i,
  output logic                 resp_valid_o,
  output logic                 resp_ok_o,
  output logic [3:0]           resp_act_o,
  output logic                 active_valid_o,
  output logic [LOC_IDX_W-1:0] active_loc_o,
  output logic                 avail_o
);
  logic                 loc_ok;
  logic [LOC_IDX_W-1:0] loc_idx;
  rid_e                 rid;
  logic                 ok, grant, rel, hstart;
  act_e                 act;

  lra_decode #(.ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .NUM_LOC(NUM_LOC), .LOC_IDX_W(LOC_IDX_W))
  u_decode (.addr_i(req_addr_i), .loc_ok_o(loc_ok), .loc_idx_o(loc_idx), .rid_o(rid));

  lra_rights #(.LOC_IDX_W(LOC_IDX_W), .DATA_W(DATA_W)) u_rights (
    .loc_ok_i(loc_ok), .loc_idx_i(loc_idx), .rid_i(rid), .write_i(req_write_i),
    .wdata_i(req_wdata_i), .act_vld_i(active_valid_o), .act_loc_i(active_loc_o),
    .avail_i(avail_o), .ok_o(ok), .act_o(act), .grant_o(grant), .release_o(rel),
    .hstart_o(hstart));

  lra_owner #(.NUM_LOC(NUM_LOC), .LOC_IDX_W(LOC_IDX_W)) u_owner (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(req_valid_i), .loc_idx_i(loc_idx),
    .grant_i(grant), .release_i(rel), .hstart_i(hstart), .avail_set_i(avail_set_i),
    .avail_clr_i(avail_clr_i), .act_vld_o(active_valid_o), .act_loc_o(active_loc_o),
    .avail_o(avail_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_ok_o    <= 1'b0;
      resp_act_o   <= 4'd0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_ok_o    <= req_valid_i && ok;
      resp_act_o   <= req_valid_i ? act : ACT_NONE;
    end
  end

  AST_ABORT_NO_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ok_o |-> resp_act_o == 4'(ACT_NONE)); // R2
  AST_STS_OWNER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_ok_o && $past(rid == RID_STS)
      |-> $past(active_valid_o && active_loc_o == loc_idx)); // R4
  AST_FIFO_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_act_o == 4'(ACT_FIFO_RD) |-> $past(avail_o)); // R8
endmodule

// File: tb/tb_lra_top.sv
`timescale 1ns/1ps
module tb_lra_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        av_set = 1'b0, av_clr = 1'b0;
  logic        resp_valid, resp_ok, act_valid, avail;
  logic [3:0]  resp_act;
  logic [2:0]  act_loc;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lra_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .avail_set_i(av_set),
    .avail_clr_i(av_clr), .resp_valid_o(resp_valid), .resp_ok_o(resp_ok),
    .resp_act_o(resp_act), .active_valid_o(act_valid), .active_loc_o(act_loc),
    .avail_o(avail));

  // reference model state
  int    m_owner = -1;
  bit    m_avail = 0;
  bit    e_valid = 0;
  int    e_act = 0;
  string e_tag = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = -1; m_avail = 0; e_valid = 0; e_act = 0; e_tag = "R1";
    end else begin
      int loc, off, nxt;
      bit own, free, w;
      loc = int'(req_addr[15:12]);
      off = int'(req_addr[11:0]);
      w = req_write;
      own = (m_owner == loc);
      free = (m_owner < 0);
      nxt = m_owner;
      e_valid = req_valid;
      e_act = 0;
      e_tag = "R2";
      if (req_valid) begin
        if (loc > 4) e_tag = "R3";
        else case (off)
          'h000: begin
            e_tag = "R7"; e_act = w ? 9 : 1;
            if (w && req_wdata[5] && own) nxt = -1;
            else if (w && req_wdata[1] && free) nxt = loc;
          end
          'h008, 'h00C, 'hF00: begin e_tag = "R5"; e_act = !w ? 1 : (own ? 2 : 0); end
          'h010: begin e_tag = "R6"; e_act = !w ? 1 : (own ? 3 : 0); end
          'h014: begin e_tag = "R6"; e_act = w ? 0 : 1; end
          'h018: begin e_tag = "R4"; e_act = own ? (w ? 2 : 1) : 0; end
          'h024: begin e_tag = "R8"; e_act = w ? (own ? 5 : 0) : ((own && m_avail) ? 4 : 0); end
          'h028: begin e_tag = "R9"; if (w && (own || free)) begin e_act = 6; nxt = 4; end end
          'h02C: begin e_tag = "R10"; e_act = (w && own) ? 7 : 0; end
          'h020: begin e_tag = "R10"; if (w && own) begin e_act = 8; nxt = -1; end end
          default: e_tag = "R3";
        endcase
      end
      m_owner = nxt;
      if (av_set) m_avail = 1;
      else if (av_clr) m_avail = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(e_tag, int'(resp_valid), int'(e_valid));
      if (e_valid) begin
        chk(e_tag, int'(resp_ok), int'(e_act != 0));
        chk(e_tag, int'(resp_act), e_act);
      end
      chk(e_tag, int'(act_valid), int'(m_owner >= 0));
      if (m_owner >= 0) chk(e_tag, int'(act_loc), m_owner);
      chk("R11", int'(avail), int'(m_avail));
    end
  end

  task automatic send(input int loc, input int off, input bit w, input int d = 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {loc[3:0], off[11:0]};
    req_write = w;
    req_wdata = d[7:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic avail_pulse(input bit s, input bit c);
    @(negedge clk);
    av_set = s; av_clr = c;
    @(negedge clk);
    av_set = 1'b0; av_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(resp_valid), 0);
    chk("R1", int'(act_valid), 0);
    chk("R1", int'(avail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(resp_valid), 0);

    send(0, 'h018, 0);          // R4 none active -> abort
    send(2, 'h000, 0);          // R7 read
    send(2, 'h000, 1, 'h02);    // R7 grant loc2
    send(3, 'h000, 1, 'h02);    // R7 no change
    send(2, 'h018, 0);          // R4 owner read
    send(2, 'h018, 1);          // R4 owner write
    send(3, 'h018, 1);          // R4 other abort
    send(3, 'h008, 0);          // R5
    send(3, 'h008, 1);
    send(2, 'h00C, 1);
    send(4, 'hF00, 0);
    send(1, 'hF00, 1);
    send(2, 'h010, 1);          // R6 clear
    send(1, 'h010, 1);
    send(2, 'h014, 1);          // R6 cap write abort
    send(0, 'h014, 0);
    send(2, 'h024, 0);          // R8 no data
    avail_pulse(1, 0);
    send(2, 'h024, 0);          // R8 pop
    send(1, 'h024, 0);
    send(2, 'h024, 1);
    send(0, 'h024, 1);
    avail_pulse(1, 1);          // R11 set wins
    avail_pulse(0, 1);
    send(2, 'h024, 0);
    send(2, 'h02C, 1);          // R10 owner data
    send(3, 'h028, 1);          // R9 other -> abort
    send(2, 'h028, 1);          // R9 owner -> loc4
    send(4, 'h02C, 1);
    send(3, 'h020, 1);          // R10 abort
    send(4, 'h020, 1);          // R10 release
    send(1, 'h028, 1);          // R9 free -> loc4
    send(1, 'h000, 1, 'h20);    // R7 non-owner release ignored
    send(4, 'h000, 1, 'h20);    // R7 release
    send(5, 'h000, 0);          // R3
    send(15, 'h008, 0);
    send(0, 'h004, 0);
    send(0, 'h028, 0);          // R9 read abort
    send(0, 'h000, 1, 'h22);    // R7 grant loc0

    for (int i = 0; i < 400; i++) begin
      int offs[12] = '{'h000, 'h008, 'h00C, 'h010, 'h014, 'h018,
                       'h020, 'h024, 'h028, 'h02C, 'hF00, 'h030};
      int l = int'($urandom_range(5, 0));
      int o = offs[$urandom_range(11, 0)];
      int d = int'($urandom_range(255, 0));
      if ($urandom_range(7, 0) == 0) avail_pulse($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1);
      send(l, o, $urandom_range(1, 0) == 1, d);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule